// File: doc/BRIEF.md
# NaN Format Converter (binary32 / binary64)

This unit takes a NaN operand in either binary32 or binary64 encoding and produces the same NaN re-encoded in the other format, one clock cycle later. Internally the operand is first turned into a format-neutral canonical form: the sign bit and a wide payload with the fraction pushed against the top. The target encoding is then built from the upper bits of that payload. Widening keeps every fraction bit. Narrowing keeps only the most significant ones.

Whether an operand counts as signaling is decided at run time. A select input chooses between the modern rule, where a clear fraction MSB marks a signaling NaN, and the older rule, where a set fraction MSB marks one. A third mode treats every NaN as quiet. Converting a signaling NaN raises an invalid-operation pulse. A fixed default NaN replaces the result in two cases: when default-NaN mode is on, and when narrowing leaves no fraction bit set. That default NaN can take one of four styles.

Operands must be NaNs. Behaviour for other encodings is not defined.

Top module: `nan_fmt_conv`

## Requirements
- R1: `out_valid` is high in exactly the cycle after a cycle with `in_valid` high. While `rst` is high, `out_valid` and `out_invalid` read 0.
- R2: With `quiet_legacy`=0 and `nosnan_mode`=0, an operand is signaling when its fraction MSB is 0 and its other fraction bits are not all 0. Such an operand makes `out_invalid` pulse together with its `out_valid`. An operand with the fraction MSB set gives no pulse.
- R3: With `quiet_legacy`=1 and `nosnan_mode`=0, an operand is signaling exactly when its fraction MSB is 1, and only such an operand pulses `out_invalid`.
- R4: With `nosnan_mode`=1, `out_invalid` stays 0 for every operand and under either convention.
- R5: `dir`=0 widens. The binary32 operand sits in `in_operand[31:0]` and bits 63:32 are ignored. The result is a binary64 NaN with the same sign, an exponent of all ones, and a fraction equal to the 23-bit source fraction followed by 29 zero bits.
- R6: `dir`=1 narrows. The result sits in `out_result[31:0]` and bits 63:32 read 0. The result keeps the sign, has an all-ones exponent, and takes its fraction from source fraction bits 51:29.
- R7: If narrowing gives a 23-bit fraction of zero, the result is the default NaN of the selected style. `out_invalid` still follows R2 to R4.
- R8: With `dflt_mode`=1, the result is always the default NaN of the selected style, whatever the operand. `out_invalid` still follows R2 to R4.
- R9: `dflt_style` selects the default NaN in the target format:
  - 0: sign 0, only the fraction MSB set (binary32 7FC00000, binary64 7FF8000000000000).
  - 1: sign 0, every fraction bit except the MSB set (7FBFFFFF, 7FF7FFFFFFFFFFFF).
  - 2: sign 1, only the fraction MSB set (FFC00000, FFF8000000000000).
  - 3: sign 0, every fraction bit set (7FFFFFFF, 7FFFFFFFFFFFFFFF).
- R10: `out_result` holds its last value during cycles without `in_valid`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand present this cycle |
| in_operand | input | 64 | NaN operand; binary32 in bits 31:0 when widening |
| dir | input | 1 | 0 widens binary32 to binary64, 1 narrows binary64 to binary32 |
| quiet_legacy | input | 1 | 1 selects the convention where a set fraction MSB is signaling |
| nosnan_mode | input | 1 | 1 treats every NaN as quiet |
| dflt_mode | input | 1 | 1 forces the default NaN as result |
| dflt_style | input | 2 | Default NaN pattern select (R9) |
| out_valid | output | 1 | Result present this cycle |
| out_result | output | 64 | Converted NaN; binary32 in bits 31:0 when narrowing |
| out_invalid | output | 1 | Invalid-operation pulse, aligned with out_valid |

## Verification
The hardest case to reach is a narrowed binary64 NaN whose payload lies entirely in fraction bits 28:0. Random operands almost never leave bits 51:29 clear. The stimulus therefore builds such operands directly, under both conventions and all four styles. The random phase also clears the upper fraction bits of a quarter of its narrowing operands. Each of these operands is paired with a check that the invalid pulse still follows the source classification and is not affected by the default-NaN substitution.

// File: rtl/nan_conv_pkg.sv
package nan_conv_pkg;

  typedef enum logic [1:0] {
    DN_MSB_ONLY = 2'd0,
    DN_LEGACY   = 2'd1,
    DN_NEG_MSB  = 2'd2,
    DN_ALL_ONES = 2'd3
  } dflt_style_e;

  typedef enum logic {
    DIR_WIDEN  = 1'b0,
    DIR_NARROW = 1'b1
  } conv_dir_e;

endpackage

// File: rtl/nan_unpack.sv
module nan_unpack
  import nan_conv_pkg::*;
#(
  parameter int unsigned EXP_W   = 8,
  parameter int unsigned FRAC_W  = 23,
  parameter int unsigned CANON_W = 64,
  localparam int unsigned WORD_W = 1 + EXP_W + FRAC_W,
  localparam int unsigned PAD_W  = CANON_W - FRAC_W
) (
  input  logic [WORD_W-1:0]  word_i,
  input  logic               legacy_i,
  input  logic               nosnan_i,
  output logic               sign_o,
  output logic [CANON_W-1:0] payload_o,
  output logic               snan_o
);

  logic [FRAC_W-1:0] frac;
  logic              frac_msb;
  logic              frac_rest;
  logic [EXP_W-1:0]  unused_exp;

  assign frac       = word_i[FRAC_W-1:0];
  assign frac_msb   = frac[FRAC_W-1];
  assign frac_rest  = |frac[FRAC_W-2:0];
  assign sign_o     = word_i[WORD_W-1];
  assign unused_exp = word_i[WORD_W-2 -: EXP_W];

  always_comb begin
    if (nosnan_i)      snan_o = 1'b0;
    else if (legacy_i) snan_o = frac_msb;
    else               snan_o = ~frac_msb & frac_rest;
  end

  generate
    if (PAD_W > 0) begin : g_pad
      assign payload_o = {frac, {PAD_W{1'b0}}};
    end else begin : g_nopad
      assign payload_o = frac;
    end
  endgenerate

  initial begin
    if (CANON_W < FRAC_W) $error("canonical payload narrower than fraction");
  end

endmodule

// File: rtl/nan_default_gen.sv
module nan_default_gen
  import nan_conv_pkg::*;
#(
  parameter int unsigned EXP_W  = 8,
  parameter int unsigned FRAC_W = 23,
  localparam int unsigned WORD_W = 1 + EXP_W + FRAC_W
) (
  input  logic [1:0]        style_i,
  output logic [WORD_W-1:0] word_o
);

  logic              sgn;
  logic              msb;
  logic [FRAC_W-2:0] rest;

  always_comb begin
    sgn  = 1'b0;
    msb  = 1'b1;
    rest = '0;
    case (dflt_style_e'(style_i))
      DN_LEGACY: begin
        msb  = 1'b0;
        rest = '1;
      end
      DN_NEG_MSB:  sgn  = 1'b1;
      DN_ALL_ONES: rest = '1;
      default: ;
    endcase
    word_o = {sgn, {EXP_W{1'b1}}, msb, rest};
  end

endmodule

// File: rtl/nan_pack.sv
module nan_pack #(
  parameter int unsigned EXP_W   = 8,
  parameter int unsigned FRAC_W  = 23,
  parameter int unsigned CANON_W = 64,
  localparam int unsigned WORD_W = 1 + EXP_W + FRAC_W,
  localparam int unsigned DROP_W = CANON_W - FRAC_W
) (
  input  logic               sign_i,
  input  logic [CANON_W-1:0] payload_i,
  input  logic               force_dflt_i,
  input  logic [WORD_W-1:0]  dflt_word_i,
  output logic [WORD_W-1:0]  word_o
);

  logic [FRAC_W-1:0] frac;
  logic              frac_zero;

  assign frac      = payload_i[CANON_W-1 -: FRAC_W];
  assign frac_zero = (frac == '0);

  generate
    if (DROP_W > 0) begin : g_drop
      logic unused_low;
      assign unused_low = |payload_i[DROP_W-1:0];
    end
  endgenerate

  always_comb begin
    if (force_dflt_i || frac_zero) word_o = dflt_word_i;
    else                           word_o = {sign_i, {EXP_W{1'b1}}, frac};
  end

endmodule

// File: rtl/nan_fmt_conv.sv
module nan_fmt_conv
  import nan_conv_pkg::*;
#(
  parameter int unsigned EXP_NARROW  = 8,
  parameter int unsigned FRAC_NARROW = 23,
  parameter int unsigned EXP_WIDE    = 11,
  parameter int unsigned FRAC_WIDE   = 52,
  parameter int unsigned CANON_W     = 64,
  localparam int unsigned NARROW_W   = 1 + EXP_NARROW + FRAC_NARROW,
  localparam int unsigned WIDE_W     = 1 + EXP_WIDE + FRAC_WIDE
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [WIDE_W-1:0] in_operand,
  input  logic              dir,
  input  logic              quiet_legacy,
  input  logic              nosnan_mode,
  input  logic              dflt_mode,
  input  logic [1:0]        dflt_style,
  output logic              out_valid,
  output logic [WIDE_W-1:0] out_result,
  output logic              out_invalid
);

  logic               n_sign, w_sign, c_sign;
  logic [CANON_W-1:0] n_pay, w_pay, c_pay;
  logic               n_snan, w_snan, c_snan;
  logic [NARROW_W-1:0] dflt_narrow, res_narrow;
  logic [WIDE_W-1:0]   dflt_wide, res_wide;
  logic [WIDE_W-1:0]   next_result;
  logic                narrowing;

  assign narrowing = (conv_dir_e'(dir) == DIR_NARROW);

  nan_unpack #(.EXP_W(EXP_NARROW), .FRAC_W(FRAC_NARROW), .CANON_W(CANON_W)) u_unpack_n (
    .word_i(in_operand[NARROW_W-1:0]), .legacy_i(quiet_legacy), .nosnan_i(nosnan_mode),
    .sign_o(n_sign), .payload_o(n_pay), .snan_o(n_snan));

  nan_unpack #(.EXP_W(EXP_WIDE), .FRAC_W(FRAC_WIDE), .CANON_W(CANON_W)) u_unpack_w (
    .word_i(in_operand), .legacy_i(quiet_legacy), .nosnan_i(nosnan_mode),
    .sign_o(w_sign), .payload_o(w_pay), .snan_o(w_snan));

  assign c_sign = narrowing ? w_sign : n_sign;
  assign c_pay  = narrowing ? w_pay  : n_pay;
  assign c_snan = narrowing ? w_snan : n_snan;

  nan_default_gen #(.EXP_W(EXP_NARROW), .FRAC_W(FRAC_NARROW)) u_dflt_n (
    .style_i(dflt_style), .word_o(dflt_narrow));

  nan_default_gen #(.EXP_W(EXP_WIDE), .FRAC_W(FRAC_WIDE)) u_dflt_w (
    .style_i(dflt_style), .word_o(dflt_wide));

  nan_pack #(.EXP_W(EXP_NARROW), .FRAC_W(FRAC_NARROW), .CANON_W(CANON_W)) u_pack_n (
    .sign_i(c_sign), .payload_i(c_pay), .force_dflt_i(dflt_mode),
    .dflt_word_i(dflt_narrow), .word_o(res_narrow));

  nan_pack #(.EXP_W(EXP_WIDE), .FRAC_W(FRAC_WIDE), .CANON_W(CANON_W)) u_pack_w (
    .sign_i(c_sign), .payload_i(c_pay), .force_dflt_i(dflt_mode),
    .dflt_word_i(dflt_wide), .word_o(res_wide));

  assign next_result = narrowing ? {{(WIDE_W-NARROW_W){1'b0}}, res_narrow} : res_wide;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      out_invalid <= 1'b0;
      out_result  <= '0;
    end else begin
      out_valid   <= in_valid;
      out_invalid <= in_valid & c_snan;
      if (in_valid) out_result <= next_result;
    end
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid); // R1
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid); // R1
  AST_FLAG_WITH_VALID: assert property (@(posedge clk) disable iff (rst)
    out_invalid |-> out_valid); // R2
  AST_NOSNAN_SILENT: assert property (@(posedge clk) disable iff (rst)
    (in_valid && nosnan_mode) |=> !out_invalid); // R4
  AST_WIDE_EXP_ONES: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !dir) |=> (&out_result[WIDE_W-2 -: EXP_WIDE])); // R5
  AST_NARROW_UPPER_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (in_valid && dir) |=> (out_result[WIDE_W-1:NARROW_W] == '0 &&
                           (&out_result[NARROW_W-2 -: EXP_NARROW]))); // R6
  AST_DFLT_SIGN: assert property (@(posedge clk) disable iff (rst)
    (in_valid && dflt_mode && dir) |=>
      (out_result[NARROW_W-1] == ($past(dflt_style) == 2'd2))); // R8
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !in_valid) |=> $stable(out_result)); // R10

endmodule

// File: tb/sim_nan_fmt_conv.sv
module sim_nan_fmt_conv;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [63:0] in_operand = '0;
  logic        dir = 1'b0;
  logic        quiet_legacy = 1'b0;
  logic        nosnan_mode = 1'b0;
  logic        dflt_mode = 1'b0;
  logic [1:0]  dflt_style = 2'd0;
  logic        out_valid;
  logic [63:0] out_result;
  logic        out_invalid;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;

  typedef struct {
    logic [63:0] res;
    logic        inv;
    int          due;
    string       tag;
  } exp_t;
  exp_t q[$];

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  nan_fmt_conv u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_operand(in_operand), .dir(dir),
    .quiet_legacy(quiet_legacy), .nosnan_mode(nosnan_mode), .dflt_mode(dflt_mode),
    .dflt_style(dflt_style), .out_valid(out_valid), .out_result(out_result),
    .out_invalid(out_invalid));

  function automatic logic [63:0] dflt_of(input logic narrow, input logic [1:0] st);
    logic [63:0] r;
    if (narrow) begin
      case (st)
        2'd0: r = 64'h7FC00000;
        2'd1: r = 64'h7FBFFFFF;
        2'd2: r = 64'hFFC00000;
        default: r = 64'h7FFFFFFF;
      endcase
    end else begin
      case (st)
        2'd0: r = 64'h7FF8000000000000;
        2'd1: r = 64'h7FF7FFFFFFFFFFFF;
        2'd2: r = 64'hFFF8000000000000;
        default: r = 64'h7FFFFFFFFFFFFFFF;
      endcase
    end
    return r;
  endfunction

  function automatic void model(input logic [63:0] op, input logic d, input logic leg,
                                input logic nos, input logic dm, input logic [1:0] st,
                                output logic [63:0] res, output logic inv);
    logic top, others, s;
    logic [22:0] f23;
    if (!d) begin
      s = op[31]; top = op[22]; others = (op[21:0] != 0);
      res = {s, 11'h7FF, op[22:0], 29'd0};
    end else begin
      s = op[63]; top = op[51]; others = (op[50:0] != 0);
      f23 = op[51:29];
      res = (f23 == 0) ? dflt_of(1'b1, st) : {32'd0, s, 8'hFF, f23};
    end
    if (dm) res = dflt_of(d, st);
    inv = nos ? 1'b0 : (leg ? top : (!top && others));
  endfunction

  task automatic send(input logic [63:0] op, input logic d, input logic leg, input logic nos,
                      input logic dm, input logic [1:0] st, input string tag);
    exp_t e;
    @(negedge clk);
    in_valid = 1'b1; in_operand = op; dir = d; quiet_legacy = leg;
    nosnan_mode = nos; dflt_mode = dm; dflt_style = st;
    model(op, d, leg, nos, dm, st, e.res, e.inv);
    e.due = cyc + 1;
    e.tag = tag;
    q.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_operand = 64'hDEADBEEF_0BADF00D;
      dflt_style = dflt_style + 2'd1;
    end
  endtask

  logic [63:0] held;
  always @(negedge clk) begin
    if (!rst && !done) begin
      if (out_valid) begin
        checks++;
        if (q.size() == 0) begin
          errors++;
          $display("FAIL R1: out_valid actual 1 expected 0 (nothing pending) at cycle %0d", cyc);
        end else begin
          exp_t e;
          e = q.pop_front();
          if (e.due != cyc || out_result !== e.res || out_invalid !== e.inv) begin
            errors++;
            $display("FAIL %s: result actual %h expected %h, invalid actual %b expected %b, cycle actual %0d expected %0d",
                     e.tag, out_result, e.res, out_invalid, e.inv, cyc, e.due);
          end
        end
        held = out_result;
      end else begin
        if (q.size() != 0 && q[0].due == cyc) begin
          checks++; errors++;
          $display("FAIL R1: out_valid actual 0 expected 1 at cycle %0d", cyc);
          void'(q.pop_front());
        end
        if (out_invalid !== 1'b0) begin
          checks++; errors++;
          $display("FAIL R2: out_invalid actual %b expected 0 without out_valid", out_invalid);
        end
        if (out_result !== held) begin
          checks++; errors++;
          $display("FAIL R10: out_result actual %h expected held %h", out_result, held);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL R1: watchdog expired, actual hung expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [63:0] op;
    logic d, leg, nos, dm;
    logic [1:0] st;
    held = '0;
    in_valid = 1'b1;
    in_operand = 64'h7FF4000000000001;
    repeat (3) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || out_invalid !== 1'b0) begin
      errors++;
      $display("FAIL R1: under reset valid/invalid actual %b%b expected 00", out_valid, out_invalid);
    end
    in_valid = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    idle(2);
    checks++;
    if (out_valid !== 1'b0 || out_result !== 64'd0) begin
      errors++;
      $display("FAIL R1: after reset valid %b result %h expected 0 and 0", out_valid, out_result);
    end

    // widening, modern convention
    send(64'h00000000_7FC00001, 0, 0, 0, 0, 0, "R5 quiet widen");
    send(64'hFFFFFFFF_FF800005, 0, 0, 0, 0, 0, "R2 signaling widen");
    send(64'h12345678_7FA5A5A5, 0, 0, 0, 0, 0, "R5 upper bits ignored");
    idle(3);
    // legacy convention
    send(64'h00000000_7FC00000, 0, 1, 0, 0, 0, "R3 msb set signaling");
    send(64'h00000000_7F800001, 0, 1, 0, 0, 0, "R3 msb clear quiet");
    send(64'h7FF8000000000000, 1, 1, 0, 0, 0, "R3 narrow msb set");
    // no signaling mode
    send(64'h00000000_7F800001, 0, 0, 1, 0, 0, "R4 modern");
    send(64'h00000000_FFC00000, 0, 1, 1, 0, 0, "R4 legacy");
    idle(2);
    // narrowing
    send(64'h7FF4000000000001, 1, 0, 0, 0, 0, "R6 signaling narrow");
    send(64'hFFFC0000E0000000, 1, 0, 0, 0, 0, "R6 negative narrow");
    // narrowing to zero fraction: every style, both conventions
    for (int s = 0; s < 4; s++) begin
      send(64'h7FF0000000000001, 1, 0, 0, 0, s[1:0], "R7 zero narrow modern");
      send(64'hFFF000001FFFFFFF, 1, 1, 0, 0, s[1:0], "R7 zero narrow legacy");
    end
    // default NaN mode, every style, both directions
    for (int s = 0; s < 4; s++) begin
      send(64'h00000000_FF800003, 0, 0, 0, 1, s[1:0], "R8 forced widen");
      send(64'hFFFFFFFFFFFFFFFF, 1, 0, 0, 1, s[1:0], "R9 forced narrow");
    end
    idle(4);

    for (int i = 0; i < 400; i++) begin
      op = {$urandom(), $urandom()};
      d = $urandom_range(0, 1);
      leg = $urandom_range(0, 1);
      nos = ($urandom_range(0, 5) == 0);
      dm = ($urandom_range(0, 4) == 0);
      st = 2'($urandom_range(0, 3));
      if (!d) begin
        op[30:23] = 8'hFF;
        if (op[22:0] == 0) op[0] = 1'b1;
      end else begin
        op[62:52] = 11'h7FF;
        if ($urandom_range(0, 3) == 0) op[51:29] = '0;
        if (op[51:0] == 0) op[3] = 1'b1;
      end
      send(op, d, leg, nos, dm, st, d ? "R6 random narrow" : "R5 random widen");
      if ($urandom_range(0, 6) == 0) idle($urandom_range(1, 3));
    end
    idle(4);

    checks++;
    if (q.size() != 0) begin
      errors++;
      $display("FAIL R1: pending results actual %0d expected 0", q.size());
    end
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule